// File: doc/BRIEF.md
# Alarm Setpoint Adjuster

This block holds the hour and minute of an alarm setpoint and lets a user change them with two push buttons, one per field. Each button is active low and is first brought into the clock domain, then filtered. A press takes effect only when the key is still down after a settle window. Every accepted press adds one to its field, and the field wraps back to zero after its last legal value.

A key that stays down keeps stepping its field. After each step the key is left alone for a pacing interval and then filtered again, so a held key advances at a slow, steady rate. Every delay is counted in pulses of a 1 ms tick input, so the timing does not depend on the system clock frequency. The hour key has priority: while it is pressed or still pacing, the minute key is held off. A one-cycle strobe marks each update, so downstream logic can latch the new setpoint.

Top module: `alarm_setpoint_adjuster`

## Requirements
- R1: A synchronous active-high reset sets the hour and minute to 0, holds the change strobe low and returns both key filters to idle. A key that is still held after reset needs a full new settle window before it steps.
- R2: A key line at logic 0 means pressed. Each key line passes through two flops first. A press is accepted only if the synchronized key is still low at the 30th tick after the first low sample, and a press shorter than that changes nothing.
- R3: Each accepted hour step adds 1 to the hour. The step from 23 gives 0, so the hour always stays in the range 0 to 23.
- R4: Each accepted minute step adds 1 to the minute. The step from 59 gives 0, so the minute always stays in the range 0 to 59.
- R5: After a step, the key is not sampled for 250 ticks. If it is still low after that, a new 30-tick settle window starts, so a held key steps once every 280 ticks.
- R6: While the hour key is pressed or its filter is busy, the minute filter stays idle or drops back to idle, and the minute does not change. The minute key is served again only once the hour pacing has ended and the hour key is released.
- R7: The change strobe is high for exactly one cycle, in the same cycle that the new hour or minute value first appears. It is low in every other cycle.
- R8: Settle and pacing progress only on tick pulses. With the tick held low, a held key never steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| hour_key_n | input | 1 | Raw hour button, low when pressed |
| min_key_n | input | 1 | Raw minute button, low when pressed |
| alarm_hour | output | 5 | Alarm hour in binary, 0 to 23 |
| alarm_min | output | 6 | Alarm minute in binary, 0 to 59 |
| change_pulse | output | 1 | One-cycle strobe marking an update |

## Verification
Two functions can fall in the same cycle: the hour key becoming active, and the minute filter starting its own settle window or finishing it. If both were served, both fields could update together. The bench provokes this by driving both keys low on the same clock edge and holding them through several hour steps. It then releases only the hour key in the middle of a pacing interval. The hour must advance on its 280-tick schedule while the minute stays frozen, and the minute must take exactly one step about 30 ticks after the hour pacing ends, never during it.

// File: rtl/alarm_set_pkg.sv
package alarm_set_pkg;

  typedef enum logic [1:0] {
    KEY_IDLE   = 2'd0,
    KEY_SETTLE = 2'd1,
    KEY_PACE   = 2'd2
  } key_phase_e;

endpackage

// File: rtl/key_sync.sv
module key_sync #(
  parameter int KEYS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [KEYS-1:0] raw_n,
  output logic [KEYS-1:0] pressed
);

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    logic stage1_n, stage2_n;

    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_n <= 1'b1;
        stage2_n <= 1'b1;
      end else begin
        stage1_n <= raw_n[k];
        stage2_n <= stage1_n;
      end
    end

    assign pressed[k] = ~stage2_n;
  end

endmodule

// File: rtl/key_stepper.sv
module key_stepper
  import alarm_set_pkg::*;
#(
  parameter int SETTLE_TICKS = 30,
  parameter int PACE_TICKS   = 250,
  localparam int MAX_TICKS   = (SETTLE_TICKS > PACE_TICKS) ? SETTLE_TICKS : PACE_TICKS,
  localparam int CW          = $clog2(MAX_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       pressed,
  input  logic       grant,
  output logic       step,
  output key_phase_e phase
);

  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_TICKS - 1);
  localparam logic [CW-1:0] PACE_LAST   = CW'(PACE_TICKS - 1);

  key_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    step    = 1'b0;
    unique case (phase_q)
      KEY_IDLE: begin
        if (pressed && grant) begin
          phase_d = KEY_SETTLE;
          cnt_d   = '0;
        end
      end
      KEY_SETTLE: begin
        if (!grant) begin
          phase_d = KEY_IDLE;
        end else if (tick) begin
          if (cnt_q == SETTLE_LAST) begin
            cnt_d = '0;
            if (pressed) begin
              step    = 1'b1;
              phase_d = KEY_PACE;
            end else begin
              phase_d = KEY_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      KEY_PACE: begin
        if (tick) begin
          if (cnt_q == PACE_LAST) begin
            phase_d = KEY_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        phase_d = KEY_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= KEY_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;

  // R8: a step can only be taken on a tick pulse
  p_step_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
    step |-> tick);

  // R2: a step requires the key to still be down at the end of the settle window
  p_step_needs_key_r2: assert property (@(posedge clk) disable iff (rst)
    step |-> pressed);

  // R5: once pacing starts, the key is not served again in the next cycle
  p_pace_holds_r5: assert property (@(posedge clk) disable iff (rst)
    step |=> (phase_q == KEY_PACE));

endmodule

// File: rtl/wrap_field.sv
module wrap_field #(
  parameter int  LIMIT = 24,
  localparam int W     = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bump,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (bump) begin
      value <= (value == TOP) ? '0 : value + 1'b1;
    end
  end

  // R3 and R4: the field never leaves its legal range
  p_field_range_r3: assert property (@(posedge clk) disable iff (rst)
    value <= TOP);

  // R3 and R4: a step from the last value wraps to zero
  p_field_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (bump && value == TOP) |=> (value == '0));

endmodule

// File: rtl/alarm_setpoint_adjuster.sv
module alarm_setpoint_adjuster
  import alarm_set_pkg::*;
#(
  parameter int  SETTLE_TICKS = 30,
  parameter int  PACE_TICKS   = 250,
  parameter int  HOUR_LIMIT   = 24,
  parameter int  MIN_LIMIT    = 60,
  localparam int HOUR_W       = $clog2(HOUR_LIMIT),
  localparam int MIN_W        = $clog2(MIN_LIMIT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic              hour_key_n,
  input  logic              min_key_n,
  output logic [HOUR_W-1:0] alarm_hour,
  output logic [MIN_W-1:0]  alarm_min,
  output logic              change_pulse
);

  localparam int KEYS  = 2;
  localparam int K_HR  = 0;
  localparam int K_MIN = 1;

  logic [KEYS-1:0] key_pressed;
  logic            hour_step, min_step;
  logic            hour_busy;
  key_phase_e      hour_phase, min_phase;

  key_sync #(.KEYS(KEYS)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .raw_n   ({min_key_n, hour_key_n}),
    .pressed (key_pressed)
  );

  key_stepper #(.SETTLE_TICKS(SETTLE_TICKS), .PACE_TICKS(PACE_TICKS)) u_hour_key (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_ms),
    .pressed (key_pressed[K_HR]),
    .grant   (1'b1),
    .step    (hour_step),
    .phase   (hour_phase)
  );

  // The hour key holds off the minute key while it is pressed or still active
  assign hour_busy = (hour_phase != KEY_IDLE) || key_pressed[K_HR];

  key_stepper #(.SETTLE_TICKS(SETTLE_TICKS), .PACE_TICKS(PACE_TICKS)) u_min_key (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_ms),
    .pressed (key_pressed[K_MIN]),
    .grant   (!hour_busy),
    .step    (min_step),
    .phase   (min_phase)
  );

  wrap_field #(.LIMIT(HOUR_LIMIT)) u_hour_field (
    .clk   (clk),
    .rst   (rst),
    .bump  (hour_step),
    .value (alarm_hour)
  );

  wrap_field #(.LIMIT(MIN_LIMIT)) u_min_field (
    .clk   (clk),
    .rst   (rst),
    .bump  (min_step),
    .value (alarm_min)
  );

  always_ff @(posedge clk) begin
    if (rst) change_pulse <= 1'b0;
    else     change_pulse <= hour_step | min_step;
  end

  // R1: the cycle after a reset, both fields are zero and the strobe is quiet
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (alarm_hour == '0 && alarm_min == '0 && !change_pulse));

  // R6: a minute step never happens while the hour key is busy
  p_hour_priority_r6: assert property (@(posedge clk) disable iff (rst)
    min_step |-> !hour_busy);

  // R6: a minute settle window is dropped as soon as the hour key becomes busy
  p_min_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (hour_busy && min_phase == KEY_SETTLE) |=> (min_phase == KEY_IDLE));

  // R7: the strobe never lasts longer than one cycle
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    change_pulse |=> !change_pulse);

  // R7: with the strobe low, neither field moves
  p_quiet_without_strobe_r7: assert property (@(posedge clk) disable iff (rst || $past(rst))
    !change_pulse |-> ($stable(alarm_hour) && $stable(alarm_min)));

endmodule

// File: tb/alarm_setpoint_adjuster_tb.sv
module alarm_setpoint_adjuster_tb;

  localparam int SETTLE = 30;
  localparam int PACE   = 250;
  localparam int PERIOD = SETTLE + PACE;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms = 1'b0;
  logic       tick_en = 1'b1;
  logic       hour_key_n = 1'b1;
  logic       min_key_n = 1'b1;
  logic [4:0] alarm_hour;
  logic [5:0] alarm_min;
  logic       change_pulse;

  int checks = 0;
  int errors = 0;
  int pulse_err = 0;
  bit done = 1'b0;

  alarm_setpoint_adjuster u_dut (
    .clk          (clk),
    .rst          (rst),
    .tick_ms      (tick_ms),
    .hour_key_n   (hour_key_n),
    .min_key_n    (min_key_n),
    .alarm_hour   (alarm_hour),
    .alarm_min    (alarm_min),
    .change_pulse (change_pulse)
  );

  always #4 clk = ~clk;

  // One tick every second clock, gated by tick_en
  always @(negedge clk) tick_ms <= tick_en && !tick_ms;

  // R7 monitor: the strobe must be high exactly when a field has just changed
  logic [4:0] prev_h;
  logic [5:0] prev_m;
  logic       prev_rst = 1'b1;
  always @(negedge clk) begin
    if (!rst && !prev_rst) begin
      if (((alarm_hour != prev_h) || (alarm_min != prev_m)) != change_pulse)
        pulse_err++;
    end
    prev_h   = alarm_hour;
    prev_m   = alarm_min;
    prev_rst = rst;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk iff tick_ms);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 hour after reset", alarm_hour, 0);
    check("R1 minute after reset", alarm_min, 0);
    check("R1 strobe after reset", change_pulse, 0);

    // R2: a press shorter than the settle window is dropped
    hour_key_n = 1'b0;
    wait_ticks(20);
    hour_key_n = 1'b1;
    wait_ticks(50);
    check("R2 short press ignored", alarm_hour, 0);

    // R2/R3: settle boundary, then R5 repeat timing
    hour_key_n = 1'b0;
    wait_ticks(SETTLE - 3);
    check("R2 no step before settle", alarm_hour, 0);
    wait_ticks(6);
    check("R3 first step after settle", alarm_hour, 1);
    wait_ticks(240 - 3);
    check("R5 no step during pacing", alarm_hour, 1);
    wait_ticks(60);
    check("R5 second step after pacing", alarm_hour, 2);
    hour_key_n = 1'b1;
    wait_ticks(300);

    // R3: hour sweep through the wrap
    hour_key_n = 1'b0;
    wait_ticks(SETTLE + 140);
    for (int k = 1; k <= 24; k++) begin
      check("R3 hour sweep", alarm_hour, (2 + k) % 24);
      if (k < 24) wait_ticks(PERIOD);
    end
    hour_key_n = 1'b1;
    wait_ticks(300);

    // R4: minute sweep through the wrap
    min_key_n = 1'b0;
    wait_ticks(SETTLE + 140);
    for (int k = 1; k <= 61; k++) begin
      check("R4 minute sweep", alarm_min, k % 60);
      if (k < 61) wait_ticks(PERIOD);
    end
    min_key_n = 1'b1;
    wait_ticks(300);

    // R8: with no ticks a held key never steps
    tick_en = 1'b0;
    min_key_n = 1'b0;
    repeat (2000) @(negedge clk);
    check("R8 no step without ticks", alarm_min, 1);
    tick_en = 1'b1;
    wait_ticks(SETTLE + 3);
    check("R8 step once ticks resume", alarm_min, 2);
    min_key_n = 1'b1;
    wait_ticks(300);

    // R6: both keys pressed on the same edge
    hour_key_n = 1'b0;
    min_key_n  = 1'b0;
    wait_ticks(SETTLE + 140 + 2 * PERIOD);
    check("R6 hour steps with both held", alarm_hour, 5);
    check("R6 minute frozen with both held", alarm_min, 2);
    hour_key_n = 1'b1;
    wait_ticks(80);
    check("R6 minute waits for hour pacing", alarm_min, 2);
    wait_ticks(100);
    check("R6 minute served after hour pacing", alarm_min, 3);
    check("R6 hour unchanged after release", alarm_hour, 5);
    min_key_n = 1'b1;
    wait_ticks(300);

    // R1: reset while a key is held and pacing
    hour_key_n = 1'b0;
    wait_ticks(100);
    check("R3 hour stepped before reset", alarm_hour, 6);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 hour cleared by reset", alarm_hour, 0);
    check("R1 minute cleared by reset", alarm_min, 0);
    wait_ticks(20);
    check("R1 held key resettles after reset", alarm_hour, 0);
    wait_ticks(20);
    check("R1 step after fresh settle", alarm_hour, 1);
    hour_key_n = 1'b1;
    wait_ticks(20);

    check("R7 strobe matches every update", pulse_err, 0);
    done = 1'b1;
    finish_run();
  end

endmodule